// File: doc/BRIEF.md
# Third-Order Sinc Interpolator with Bypass

This block raises a stream of 16-bit two's-complement samples from a low host rate to a high rate. A host writes samples at the low rate. The block smooths them with a third-order sinc (cascaded integrator-comb) interpolator and presents one filtered sample per output strobe. The output strobe rate is the clock divided by `OUT_DIV`. The interpolation ratio N is chosen at run time from four settings, so one low-rate period lasts N output strobes. The downstream modulator consumes the output at a fixed rate.

The input is a valid/ready stream. `s_ready` stays high once reset is released, so the block never applies back-pressure. Every beat with `s_valid` high is taken into a single holding register, and a later beat overwrites an earlier one. Once per low-rate period the filter takes the held sample. When the host sends nothing during a period, the filter takes the same sample again. The output has no ready input, because it cannot be stalled. Each beat is a one-cycle `m_valid` pulse with `m_data`.

A bypass bit removes the filter from the path. In bypass the held sample is repeated on every output strobe, with no filter latency. Any change of the rate select or the bypass bit clears all filter state and the output register.

Top module: `sinc3_interp`

## Requirements
- R1: `s_ready` is low during reset and high from the second clock after reset release. Each cycle with `s_valid` high is accepted. When several beats arrive within one low-rate period, the last one is the sample that is used.
- R2: `rate_sel` selects N as 0→32, 1→64, 2→128, 3→256. `m_valid` is a single-cycle pulse exactly once every `OUT_DIV` (default 8) clocks, and one low-rate period spans N pulses.
- R3: In filter mode, a constant held sample x gives `m_data` equal to x exactly once the filter has settled. This holds for x = 0x7FFF (positive full scale) and 0x8000 (negative full scale). Results beyond these limits saturate to them.
- R4: With no new write, the held sample is reused every period, and the settled output stays at that value on every strobe.
- R5: After an upward step of the held sample in filter mode, the output first equals the new value after more than 2N and at most 4N strobes, counted from the write.
- R6: During an upward step, every output lies between the old and new values and does not decrease from one strobe to the next.
- R7: The clock edge that samples a change of `rate_sel` or `bypass` clears all filter state. One cycle later `m_valid` is low and `m_data` is 0. In filter mode the first strobe after the change carries 0.
- R8: In bypass, each strobe carries the held sample. A new write appears no later than the second strobe after the write.
- R9: During reset `m_valid` and `m_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_sel | input | 2 | Interpolation ratio select (N = 32 << rate_sel) |
| bypass | input | 1 | 1 = skip filter, repeat the held sample |
| s_valid | input | 1 | Host sample valid |
| s_ready | output | 1 | Sample accepted (high after reset) |
| s_data | input | 16 | Host sample, two's complement |
| m_valid | output | 1 | One-cycle output strobe |
| m_data | output | 16 | Output sample, two's complement |

## Verification
The integrators never forget an error. A corrupted accumulator or a comb that subtracts the wrong delay leaves a lasting offset or a runaway ramp. This shows as a wrong settled value on every later strobe, and it persists until the next mode change clears it. A fault in the timing counters shows within one strobe interval as wrong pulse spacing. Over a step it shows as a settling count outside the window for the selected N. A missing clear shows on the very first strobe after a mode change, as a nonzero value.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
  localparam int ORDER      = 3;
  localparam int RATE_W     = 2;
  localparam int RATE_STEPS = 2 ** RATE_W;

  // log2 of the interpolation ratio for a given select code
  function automatic int log_ratio(input int min_log, input logic [RATE_W-1:0] sel);
    return min_log + int'(sel);
  endfunction
endpackage

// File: rtl/sinc3_rate_timer.sv
module sinc3_rate_timer
  import sinc3_pkg::*;
#(
  parameter int OUT_DIV   = 8,
  parameter int MIN_LOG_N = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [RATE_W-1:0] sel,
  output logic              hi_tick,
  output logic              first_tick,
  output logic              lo_tick
);
  localparam int DW = (OUT_DIV > 2) ? $clog2(OUT_DIV) : 1;
  localparam int HW = MIN_LOG_N + RATE_STEPS - 1;

  logic [DW-1:0] div_q;
  logic [HW-1:0] ph_q;
  logic [HW-1:0] ph_last;

  always_comb ph_last = HW'((1 << log_ratio(MIN_LOG_N, sel)) - 1);

  assign hi_tick    = (div_q == DW'(OUT_DIV - 1));
  assign first_tick = hi_tick && (ph_q == '0);
  assign lo_tick    = hi_tick && (ph_q == ph_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (clr) begin
      div_q <= '0;
      ph_q  <= '0;
    end else if (hi_tick) begin
      div_q <= '0;
      ph_q  <= (ph_q == ph_last) ? '0 : ph_q + 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) ph_q <= ph_last); // R2
endmodule

// File: rtl/sinc3_comb_chain.sv
module sinc3_comb_chain
  import sinc3_pkg::*;
#(
  parameter int IN_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic        [IN_W-1:0]  x,
  output logic signed [ACC_W-1:0] y
);
  logic signed [ACC_W-1:0] diff [ORDER+1];

  assign diff[0] = {{(ACC_W-IN_W){x[IN_W-1]}}, x};

  for (genvar k = 0; k < ORDER; k++) begin : g_comb
    logic signed [ACC_W-1:0] dly_q;
    assign diff[k+1] = diff[k] - dly_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dly_q <= '0;
      else if (clr)    dly_q <= '0;
      else if (en)     dly_q <= diff[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      y <= '0;
    else if (clr)    y <= '0;
    else if (en)     y <= diff[ORDER];
  end
endmodule

// File: rtl/sinc3_integ_chain.sv
module sinc3_integ_chain
  import sinc3_pkg::*;
#(
  parameter int ACC_W = 40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    inject,
  input  logic signed [ACC_W-1:0] u,
  output logic signed [ACC_W-1:0] z
);
  logic signed [ACC_W-1:0] acc [ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_integ
    logic signed [ACC_W-1:0] sum_q;
    logic signed [ACC_W-1:0] add_in;
    if (k == 0) begin : g_head
      assign add_in = inject ? u : '0;
    end else begin : g_tail
      assign add_in = acc[k-1];
    end
    assign acc[k] = sum_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (clr)    sum_q <= '0;
      else if (en)     sum_q <= sum_q + add_in;
    end
  end

  assign z = acc[ORDER-1];
endmodule

// File: rtl/sinc3_out_stage.sv
module sinc3_out_stage
  import sinc3_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int ACC_W     = 40,
  parameter int MIN_LOG_N = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic                    bypass,
  input  logic [RATE_W-1:0]       sel,
  input  logic signed [ACC_W-1:0] acc,
  input  logic [SAMPLE_W-1:0]     held,
  output logic                    m_valid,
  output logic [SAMPLE_W-1:0]     m_data
);
  localparam logic signed [ACC_W-1:0] POS_FS = {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] NEG_FS = {{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;
  logic [SAMPLE_W-1:0]     sat;
  logic [SAMPLE_W-1:0]     pick;

  always_comb begin
    // DC gain of the interpolator is N^2, so drop 2*log2(N) bits
    scaled = acc >>> (2 * log_ratio(MIN_LOG_N, sel));
    if (scaled > POS_FS)      sat = POS_FS[SAMPLE_W-1:0];
    else if (scaled < NEG_FS) sat = NEG_FS[SAMPLE_W-1:0];
    else                      sat = scaled[SAMPLE_W-1:0];
    pick = bypass ? held : sat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (clr) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      m_valid <= en;
      if (en) m_data <= pick;
    end
  end
endmodule

// File: rtl/sinc3_interp.sv
module sinc3_interp
  import sinc3_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int OUT_DIV   = 8,
  parameter int MIN_LOG_N = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [RATE_W-1:0]   rate_sel,
  input  logic                bypass,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                m_valid,
  output logic [SAMPLE_W-1:0] m_data
);
  localparam int ACC_W = SAMPLE_W + ORDER * (MIN_LOG_N + RATE_STEPS - 1);

  logic                ready_q;
  logic [SAMPLE_W-1:0] hold_q;
  logic [RATE_W-1:0]   sel_q;
  logic                byp_q;
  logic                clr;
  logic                hi_tick, first_tick, lo_tick;
  logic signed [ACC_W-1:0] comb_y, integ_z;

  assign clr     = (rate_sel != sel_q) || (bypass != byp_q);
  assign s_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      hold_q  <= '0;
      sel_q   <= '0;
      byp_q   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      sel_q   <= rate_sel;
      byp_q   <= bypass;
      if (s_valid && ready_q) hold_q <= s_data;
    end
  end

  sinc3_rate_timer #(.OUT_DIV(OUT_DIV), .MIN_LOG_N(MIN_LOG_N)) i_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sel(sel_q),
    .hi_tick(hi_tick), .first_tick(first_tick), .lo_tick(lo_tick)
  );

  sinc3_comb_chain #(.IN_W(SAMPLE_W), .ACC_W(ACC_W)) i_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(lo_tick), .x(hold_q), .y(comb_y)
  );

  sinc3_integ_chain #(.ACC_W(ACC_W)) i_integ (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(hi_tick), .inject(first_tick),
    .u(comb_y), .z(integ_z)
  );

  sinc3_out_stage #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .MIN_LOG_N(MIN_LOG_N)) i_out (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(hi_tick), .bypass(byp_q), .sel(sel_q),
    .acc(integ_z), .held(hold_q), .m_valid(m_valid), .m_data(m_data)
  );

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n) $past(rst_n) |-> s_ready); // R1
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n) m_valid |=> !m_valid); // R2
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_n) !s_valid |=> $stable(hold_q)); // R4
  AST_CLEAR_OUT: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (!m_valid && m_data == '0)); // R7
  AST_BYPASS_ZOH: assert property (@(posedge clk) disable iff (!rst_n)
    (byp_q && m_valid && !$past(s_valid)) |-> (m_data == hold_q)); // R8
endmodule

// File: tb/test_sinc3_interp.sv
module test_sinc3_interp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  rate_sel;
  logic        bypass;
  logic        s_valid;
  logic        s_ready;
  logic [15:0] s_data;
  logic        m_valid;
  logic [15:0] m_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk; // 250 MHz

  sinc3_interp i_sinc3_interp (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .bypass(bypass),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_data(m_data)
  );

  // {rate_sel, sample}; the settled output must equal the sample
  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 16'h1234}, {2'd1, 16'hFFFB}, {2'd2, 16'h7FFF},
    {2'd3, 16'h8000}, {2'd0, 16'h0000}, {2'd1, 16'h0100}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_strobe();
    do @(negedge clk); while (!m_valid);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) next_strobe();
  endtask

  task automatic push(input logic [15:0] v);
    s_valid = 1'b1;
    s_data  = v;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic settle(input logic [1:0] r);
    int n;
    int cnt;
    bit mono;
    logic signed [15:0] prev;
    n = 32 << r;
    rate_sel = r;
    bypass   = 1'b0;
    @(negedge clk);
    push(16'h0000);
    strobes(6 * n);
    push(16'h4000);
    cnt  = 0;
    mono = 1'b1;
    prev = 16'sh0000;
    while (cnt < 8 * n) begin
      next_strobe();
      cnt++;
      if ($signed(m_data) < prev || $signed(m_data) > 16'sh4000) mono = 1'b0;
      prev = $signed(m_data);
      if (m_data == 16'h4000) break;
    end
    check(cnt > 2 * n && cnt <= 4 * n, "R5 settle strobes", 16'(cnt), 16'(3 * n));
    check(mono, "R6 monotone step", m_data, 16'h4000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    rst_n    = 1'b0;
    rate_sel = 2'd0;
    bypass   = 1'b0;
    s_valid  = 1'b0;
    s_data   = '0;
    repeat (3) @(negedge clk);
    check(!m_valid, "R9 valid in reset", {15'd0, m_valid}, 16'd0);
    check(m_data == 16'h0, "R9 data in reset", m_data, 16'h0);
    check(!s_ready, "R1 ready in reset", {15'd0, s_ready}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(s_ready, "R1 ready after reset", {15'd0, s_ready}, 16'd1);

    // R2: strobe spacing
    next_strobe();
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!m_valid);
    check(cyc == 8, "R2 strobe spacing", 16'(cyc), 16'd8);

    // Vector table: R3 settled value, R4 reuse without writes
    for (int i = 0; i < NV; i++) begin
      int n;
      int bad;
      n = 32 << VEC[i][17:16];
      rate_sel = VEC[i][17:16];
      @(negedge clk);
      push(VEC[i][15:0]);
      strobes(6 * n);
      check(m_data == VEC[i][15:0], "R3 settled value", m_data, VEC[i][15:0]);
      bad = 0;
      for (int j = 0; j < n; j++) begin
        next_strobe();
        if (m_data != VEC[i][15:0]) bad++;
      end
      check(bad == 0, "R4 held sample reused", m_data, VEC[i][15:0]);
    end

    // R7: rate change clears state (output was 0x0100)
    rate_sel = 2'd0;
    @(negedge clk);
    check(!m_valid && m_data == 16'h0, "R7 cleared next cycle", m_data, 16'h0);
    next_strobe();
    check(m_data == 16'h0, "R7 first strobe zero", m_data, 16'h0);

    settle(2'd0);
    settle(2'd1);

    // R1: last write within a period wins
    rate_sel = 2'd0;
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = 16'h1111;
    @(negedge clk);
    s_data  = 16'h2222;
    @(negedge clk);
    s_valid = 1'b0;
    strobes(6 * 32);
    check(m_data == 16'h2222, "R1 last write used", m_data, 16'h2222);

    // R8: bypass
    bypass = 1'b1;
    @(negedge clk);
    check(!m_valid && m_data == 16'h0, "R7 bypass entry clears", m_data, 16'h0);
    next_strobe();
    check(m_data == 16'h2222, "R8 bypass repeats held", m_data, 16'h2222);
    push(16'h5A5A);
    strobes(2);
    check(m_data == 16'h5A5A, "R8 bypass write", m_data, 16'h5A5A);
    push(16'hA5A5);
    strobes(2);
    check(m_data == 16'hA5A5, "R8 bypass negative write", m_data, 16'hA5A5);

    // R7: leaving bypass restarts the filter from zero
    bypass = 1'b0;
    @(negedge clk);
    next_strobe();
    check(m_data == 16'h0, "R7 filter restart zero", m_data, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule